// File: doc/BRIEF.md
# Integer ALU with Shifter

A purely combinational 32-bit execution unit for the integer pipe of a load/store RISC core. Each cycle it takes two register operands (`rs_i`, `rt_i`), a 16-bit immediate, a 5-bit shift amount and an operation code. It returns a result word, a register write strobe and an overflow flag. The core writes `result_o` to the destination register only when `we_o` is high.

The unit handles wrapping and trapping addition and subtraction, the four bitwise functions, their immediate forms, signed and unsigned set-on-less-than, upper-immediate load, and the three shift kinds. Each shift kind has two forms: the amount comes either from the instruction field or from a register. The trapping forms withhold the write when signed overflow occurs, so the destination register keeps its old value.

Top module: `int_alu`

## Requirements
- R1: ADD, ADDU, ADDI and ADDIU return the operand sum modulo 2^32. SUB and SUBU return `rs_i - rt_i` modulo 2^32. This applies whenever no trap is raised.
- R2: ADD, ADDI and SUB raise `ovf_o` and drop `we_o` exactly when the two's-complement result overflows. Overflow is detected as follows. For addition, both operands have the same sign and the sum's sign differs. For subtraction, the operand signs differ and the result's sign differs from `rs_i`.
- R3: ADDU, ADDIU and SUBU never raise `ovf_o`.
- R4: AND, OR, XOR and NOR combine `rs_i` and `rt_i` bitwise. NOR is the complement of OR.
- R5: ANDI, ORI and XORI use the immediate with 16 zero bits prepended.
- R6: ADDI, ADDIU, SLTI and SLTIU sign-extend the immediate from its bit 15.
- R7: LUI returns the immediate in bits 31..16 and zeros in bits 15..0.
- R8: SLT and SLTI return 1 when `rs_i` is less than the second operand as signed integers, and 0 otherwise.
- R9: SLTU and SLTIU compare as unsigned integers. SLTIU uses the sign-extended immediate. The result is 1 or 0.
- R10: SLL shifts `rt_i` left by `shamt_i` with zero fill. SRL shifts it right with zero fill. SRA shifts it right, filling with copies of bit 31.
- R11: SLLV, SRLV and SRAV shift `rt_i` by `rs_i[4:0]`. The upper bits of `rs_i` and all of `shamt_i` have no effect.
- R12: A shift amount of zero returns `rt_i` unchanged for every shift kind.
- R13: `we_o` is high and `ovf_o` is low for every operation that does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_i | input | 32 | First register operand; supplies the amount for variable shifts |
| rt_i | input | 32 | Second register operand; the shifted value |
| imm_i | input | 16 | Instruction immediate |
| shamt_i | input | 5 | Instruction shift amount |
| op_i | input | 5 | Operation code, values from `int_alu_pkg::alu_op_e` |
| result_o | output | 32 | Result word |
| we_o | output | 1 | Destination write strobe |
| ovf_o | output | 1 | Signed overflow on a trapping operation |

## Verification
The arithmetic operations are driven across operand-sign combinations at the overflow edges: 0x7fffffff+1, 0x80000000-1, and mixed signs that cannot overflow. These cases separate a correct overflow rule from one that only looks at the carry out. The immediate forms use immediates with bit 15 set, which exposes any mix-up between zero and sign extension. The compare operations use negative-against-positive pairs, which return opposite answers under signed and unsigned order. The shifts use a negative `rt_i` at amounts 0, 1, 16 and 31, which separates the three fill rules. Variable shifts carry junk in `rs_i[31:5]` and in `shamt_i`. A seeded random sweep over all operations completes the run.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
    OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_ADDI, OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI, OP_LUI,
    OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU,
    OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV
  } alu_op_e;

  typedef enum logic [1:0] {LF_AND, LF_OR, LF_XOR, LF_NOR} logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         slt_o,
  output logic         sltu_o
);
  logic [W-1:0] b_x;
  logic [W:0]   full;

  assign b_x   = b_i ^ {W{sub_i}};
  assign full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];
  // same-sign inputs to the adder, different-sign output
  assign ovf_o  = (a_i[W-1] == b_x[W-1]) && (sum_o[W-1] != a_i[W-1]);
  assign slt_o  = sum_o[W-1] ^ ovf_o;
  assign sltu_o = ~full[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]               a_i,
  input  logic [W-1:0]               b_i,
  input  int_alu_pkg::logic_fn_e     fn_i,
  output logic [W-1:0]               y_o
);
  import int_alu_pkg::*;
  always_comb begin
    unique case (fn_i)
      LF_AND:  y_o = a_i & b_i;
      LF_OR:   y_o = a_i | b_i;
      LF_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  y_o
);
  logic [W-1:0] pre, post;
  logic         fill;

  assign fill = arith_i & ~left_i & data_i[W-1];

  // left shift = right shift of the bit-reversed word
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign pre[g] = left_i ? data_i[W-1-g] : data_i[g];
    assign y_o[g] = left_i ? post[W-1-g]   : post[g];
  end

  always_comb begin
    post = pre;
    for (int s = 0; s < SW; s++) begin
      if (amt_i[s])
        post = (post >> (1 << s)) | (fill ? ~({W{1'b1}} >> (1 << s)) : '0);
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]           rs_i,
  input  logic [DATA_W-1:0]           rt_i,
  input  logic [IMM_W-1:0]            imm_i,
  input  logic [SH_W-1:0]             shamt_i,
  input  logic [int_alu_pkg::OP_W-1:0] op_i,
  output logic [DATA_W-1:0]           result_o,
  output logic                        we_o,
  output logic                        ovf_o
);
  import int_alu_pkg::*;
  localparam int EXT_W = DATA_W - IMM_W;

  alu_op_e       op;
  logic [DATA_W-1:0] imm_sx, imm_zx, opb, as_sum, lg_y, sh_y;
  logic          as_sub, as_ovf, as_slt, as_sltu, trap_op;
  logic          sh_left, sh_arith, sh_var;
  logic [SH_W-1:0] sh_amt;
  logic_fn_e     lf;

  assign op     = alu_op_e'(op_i);
  assign imm_sx = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zx = {{EXT_W{1'b0}}, imm_i};

  always_comb begin
    unique case (op)
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: opb = imm_sx;
      OP_ANDI, OP_ORI, OP_XORI:             opb = imm_zx;
      default:                              opb = rt_i;
    endcase
  end

  assign as_sub  = !(op inside {OP_ADD, OP_ADDU, OP_ADDI, OP_ADDIU});
  assign trap_op = op inside {OP_ADD, OP_ADDI, OP_SUB};

  alu_addsub #(.W(DATA_W)) u_as (
    .a_i(rs_i), .b_i(opb), .sub_i(as_sub),
    .sum_o(as_sum), .ovf_o(as_ovf), .slt_o(as_slt), .sltu_o(as_sltu)
  );

  always_comb begin
    unique case (op)
      OP_AND, OP_ANDI: lf = LF_AND;
      OP_OR,  OP_ORI:  lf = LF_OR;
      OP_XOR, OP_XORI: lf = LF_XOR;
      default:         lf = LF_NOR;
    endcase
  end

  alu_logic #(.W(DATA_W)) u_lg (.a_i(rs_i), .b_i(opb), .fn_i(lf), .y_o(lg_y));

  assign sh_var   = op inside {OP_SLLV, OP_SRLV, OP_SRAV};
  assign sh_left  = op inside {OP_SLL, OP_SLLV};
  assign sh_arith = op inside {OP_SRA, OP_SRAV};
  assign sh_amt   = sh_var ? rs_i[SH_W-1:0] : shamt_i;

  alu_shifter #(.W(DATA_W), .SW(SH_W)) u_sh (
    .data_i(rt_i), .amt_i(sh_amt), .left_i(sh_left), .arith_i(sh_arith), .y_o(sh_y)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU: result_o = as_sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR, OP_ANDI, OP_ORI, OP_XORI: result_o = lg_y;
      OP_LUI:               result_o = {imm_i, {EXT_W{1'b0}}};
      OP_SLT, OP_SLTI:      result_o = {{(DATA_W-1){1'b0}}, as_slt};
      OP_SLTU, OP_SLTIU:    result_o = {{(DATA_W-1){1'b0}}, as_sltu};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: result_o = sh_y;
      default:              result_o = '0;
    endcase
  end

  assign ovf_o = trap_op & as_ovf;
  assign we_o  = ~ovf_o;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input logic [DATA_W-1:0]            rs_i,
  input logic [DATA_W-1:0]            rt_i,
  input logic [SH_W-1:0]              shamt_i,
  input logic [int_alu_pkg::OP_W-1:0] op_i,
  input logic [DATA_W-1:0]            result_o,
  input logic                         we_o,
  input logic                         ovf_o
);
  import int_alu_pkg::*;
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    p_trap_blocks_write_r2: assert (!ovf_o || !we_o);
    p_trap_only_checked_r2: assert (!ovf_o || (op inside {OP_ADD, OP_ADDI, OP_SUB}));
    p_no_overflow_r3: assert (!(op inside {OP_ADDU, OP_ADDIU, OP_SUBU}) || !ovf_o);
    p_lui_low_zero_r7: assert (op != OP_LUI || result_o[15:0] == 16'h0);
    p_cmp_bool_r8: assert (!(op inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU})
                           || result_o[DATA_W-1:1] == '0);
    p_shift_zero_r12: assert (!((op inside {OP_SLL, OP_SRL, OP_SRA}) && shamt_i == '0)
                              || result_o == rt_i);
    p_vshift_zero_r12: assert (!((op inside {OP_SLLV, OP_SRLV, OP_SRAV}) && rs_i[SH_W-1:0] == '0)
                               || result_o == rt_i);
    p_write_when_clean_r13: assert (ovf_o || we_o);
  end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
  .rs_i(rs_i), .rt_i(rt_i), .shamt_i(shamt_i), .op_i(op_i),
  .result_o(result_o), .we_o(we_o), .ovf_o(ovf_o)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;
  import int_alu_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] rs, rt, res;
  logic [15:0] imm;
  logic [4:0]  sh;
  logic [4:0]  op;
  logic        we, ovf;

  int_alu u0 (
    .rs_i(rs), .rt_i(rt), .imm_i(imm), .shamt_i(sh), .op_i(op),
    .result_o(res), .we_o(we), .ovf_o(ovf)
  );

  typedef struct {
    logic [31:0] r;
    logic        w;
    logic        o;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic exp_t model(alu_op_e o, logic [31:0] a, logic [31:0] b,
                                 logic [15:0] i, logic [4:0] s, string tag);
    exp_t e;
    logic [31:0] sx, zx, r;
    logic v;
    sx = {{16{i[15]}}, i};
    zx = {16'h0, i};
    v = 1'b0;
    case (o)
      OP_ADD:   begin r = a + b;  v = (a[31] == b[31]) && (r[31] != a[31]); end
      OP_ADDI:  begin r = a + sx; v = (a[31] == sx[31]) && (r[31] != a[31]); end
      OP_SUB:   begin r = a - b;  v = (a[31] != b[31]) && (r[31] != a[31]); end
      OP_ADDU:  r = a + b;
      OP_ADDIU: r = a + sx;
      OP_SUBU:  r = a - b;
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_NOR:   r = ~(a | b);
      OP_ANDI:  r = a & zx;
      OP_ORI:   r = a | zx;
      OP_XORI:  r = a ^ zx;
      OP_LUI:   r = {i, 16'h0};
      OP_SLT:   r = {31'h0, $signed(a) < $signed(b)};
      OP_SLTI:  r = {31'h0, $signed(a) < $signed(sx)};
      OP_SLTU:  r = {31'h0, a < b};
      OP_SLTIU: r = {31'h0, a < sx};
      OP_SLL:   r = b << s;
      OP_SRL:   r = b >> s;
      OP_SRA:   r = $unsigned($signed(b) >>> s);
      OP_SLLV:  r = b << a[4:0];
      OP_SRLV:  r = b >> a[4:0];
      OP_SRAV:  r = $unsigned($signed(b) >>> a[4:0]);
      default:  r = 32'h0;
    endcase
    e.r = r; e.w = !v; e.o = v; e.tag = tag;
    return e;
  endfunction

  task automatic drive(alu_op_e o, logic [31:0] a, logic [31:0] b,
                       logic [15:0] i, logic [4:0] s, string tag);
    @(posedge clk);
    rs = a; rt = b; imm = i; sh = s; op = o;
    q.push_back(model(o, a, b, i, s, tag));
  endtask

  // monitor: outputs settle after the posedge drive, compare at negedge
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (ovf !== e.o || we !== e.w || (!e.o && res !== e.r)) begin
        bad++;
        $display("FAIL %s: act res=%h we=%b ovf=%b exp res=%h we=%b ovf=%b",
                 e.tag, res, we, ovf, e.r, e.w, e.o);
      end
    end
  end

  initial begin
    rs = '0; rt = '0; imm = '0; sh = '0; op = OP_ADD;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    drive(OP_ADD, 32'h0, 32'h0, 16'h0, 5'd0, "R13 idle zero");
    // R1/R2 arithmetic and overflow edges
    drive(OP_ADD,  32'h0000_0005, 32'h0000_0007, 16'h0, 5'd0, "R1 add small");
    drive(OP_ADD,  32'h7fff_ffff, 32'h0000_0001, 16'h0, 5'd0, "R2 add pos ovf");
    drive(OP_ADD,  32'h8000_0000, 32'hffff_ffff, 16'h0, 5'd0, "R2 add neg ovf");
    drive(OP_ADD,  32'h7fff_ffff, 32'hffff_ffff, 16'h0, 5'd0, "R2 add mixed no ovf");
    drive(OP_ADD,  32'hffff_ffff, 32'h0000_0001, 16'h0, 5'd0, "R2 carry not ovf");
    drive(OP_SUB,  32'h8000_0000, 32'h0000_0001, 16'h0, 5'd0, "R2 sub ovf");
    drive(OP_SUB,  32'h7fff_ffff, 32'hffff_ffff, 16'h0, 5'd0, "R2 sub pos ovf");
    drive(OP_SUB,  32'h0000_0003, 32'h0000_0009, 16'h0, 5'd0, "R1 sub wrap");
    drive(OP_ADDI, 32'h7fff_fff0, 32'h0, 16'h0010, 5'd0, "R2 addi ovf");
    drive(OP_ADDI, 32'h0000_0010, 32'h0, 16'hfff0, 5'd0, "R6 addi negimm");
    // R3 unsigned forms never trap
    drive(OP_ADDU,  32'h7fff_ffff, 32'h1, 16'h0, 5'd0, "R3 addu");
    drive(OP_SUBU,  32'h8000_0000, 32'h1, 16'h0, 5'd0, "R3 subu");
    drive(OP_ADDIU, 32'h7fff_ffff, 32'h0, 16'h0001, 5'd0, "R3 addiu");
    drive(OP_ADDIU, 32'h0000_0000, 32'h0, 16'h8000, 5'd0, "R6 addiu sext");
    // R4/R5 logic
    drive(OP_AND, 32'hf0f0_1234, 32'h0ff0_ffff, 16'h0, 5'd0, "R4 and");
    drive(OP_OR,  32'hf0f0_0000, 32'h0f00_00ff, 16'h0, 5'd0, "R4 or");
    drive(OP_XOR, 32'haaaa_5555, 32'hffff_0000, 16'h0, 5'd0, "R4 xor");
    drive(OP_NOR, 32'h1200_0034, 32'h0000_5600, 16'h0, 5'd0, "R4 nor");
    drive(OP_ANDI, 32'hffff_ffff, 32'h0, 16'h8001, 5'd0, "R5 andi zext");
    drive(OP_ORI,  32'h0000_0000, 32'h0, 16'hf00f, 5'd0, "R5 ori zext");
    drive(OP_XORI, 32'h1234_5678, 32'h0, 16'hffff, 5'd0, "R5 xori zext");
    drive(OP_LUI,  32'hdead_beef, 32'h0, 16'h8765, 5'd0, "R7 lui");
    // R8/R9 compares
    drive(OP_SLT,   32'hffff_ffff, 32'h0000_0001, 16'h0, 5'd0, "R8 slt neg<pos");
    drive(OP_SLT,   32'h0000_0005, 32'h0000_0005, 16'h0, 5'd0, "R8 slt equal");
    drive(OP_SLT,   32'h7fff_ffff, 32'h8000_0000, 16'h0, 5'd0, "R8 slt extremes");
    drive(OP_SLTI,  32'hffff_fff0, 32'h0, 16'hffff, 5'd0, "R8 slti");
    drive(OP_SLTU,  32'hffff_ffff, 32'h0000_0001, 16'h0, 5'd0, "R9 sltu");
    drive(OP_SLTU,  32'h0000_0001, 32'hffff_ffff, 16'h0, 5'd0, "R9 sltu small");
    drive(OP_SLTIU, 32'h7fff_0000, 32'h0, 16'h8000, 5'd0, "R9 sltiu sext");
    // R10/R12 fixed shifts
    for (int k = 0; k < 4; k++) begin
      logic [4:0] a5;
      a5 = (k == 0) ? 5'd0 : (k == 1) ? 5'd1 : (k == 2) ? 5'd16 : 5'd31;
      drive(OP_SLL, 32'h0, 32'h8765_4321, 16'h0, a5, (k == 0) ? "R12 sll zero" : "R10 sll");
      drive(OP_SRL, 32'h0, 32'h8765_4321, 16'h0, a5, (k == 0) ? "R12 srl zero" : "R10 srl");
      drive(OP_SRA, 32'h0, 32'h8765_4321, 16'h0, a5, (k == 0) ? "R12 sra zero" : "R10 sra");
    end
    // R11 variable shifts: junk in rs upper bits and in shamt
    drive(OP_SLLV, 32'hffff_ffe4, 32'h0000_00f1, 16'h0, 5'd9,  "R11 sllv");
    drive(OP_SRLV, 32'h1234_5668, 32'hf000_0000, 16'h0, 5'd1,  "R11 srlv");
    drive(OP_SRAV, 32'hffff_ff1f, 32'h8000_0000, 16'h0, 5'd3,  "R11 srav");
    drive(OP_SRAV, 32'hffff_ffe0, 32'h8000_1234, 16'h0, 5'd7,  "R12 srav zero");
    // random sweep
    for (int n = 0; n < 600; n++) begin
      alu_op_e o;
      o = alu_op_e'(n % 24);
      drive(o, $urandom, $urandom, 16'($urandom), 5'($urandom), "R1 sweep");
    end
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule